// File: doc/BRIEF.md
# Configurable-Mode Byte Stream SPI Master

This block moves a run of bytes between a local byte buffer and an SPI slave. The buffer owner fills the buffer, puts a byte count on `run_len` and a configuration byte on `cfg`, and pulses `start`. The block then asserts chip select and shifts every byte out on MOSI. Each byte it receives on MISO is written back over the buffer slot of the byte it just sent. `busy` stays high until chip select is released again. A receive-only run is therefore done by loading filler bytes.

The configuration byte chooses the SCLK rate, the clock polarity and phase, and the bit order within a byte. All four settings are captured when a run starts. Words are always 8 bits. Chip select is held low for the whole run, with no release and no gap between bytes. The buffer has a combinational read port (`buf_rdata` shows the byte at `buf_raddr` in the same cycle) and a one-cycle write strobe.

Top module: `spi_byte_master`

## Requirements
- R1: During and right after reset, `sclk` is 0, `cs_n` is 1, `busy` is 0 and `buf_we` is 0.
- R2: A `start` pulse while idle, with 1 <= `run_len` <= MAX_RUN (default 200), makes `cs_n` low and `busy` high from the next cycle on, and `sclk` takes the level of the CPOL bit.
- R3: `cfg` is captured only at the accepted start. Changing `cfg` or pulsing `start` during a run changes neither its timing nor its data.
- R4: Config bit 3 (CPOL) sets the SCLK idle level. Config bit 2 (CPHA) = 0 samples MISO on the leading edge and changes MOSI on the trailing edge, with the first bit valid before the first edge. CPHA = 1 changes MOSI on the leading edge and samples on the trailing edge. Each byte takes exactly 16 SCLK edges.
- R5: Config bit 5 = 1 sends and receives each byte least significant bit first. Bit 5 = 0 sends and receives most significant bit first.
- R6: Config bits 1:0 set SCLK to the system clock divided by 4, 16, 64 or 128 (codes 0, 1, 2, 3). Successive SCLK edges are therefore 2, 8, 32 or 64 cycles apart.
- R7: Chip select stays low from start until the run ends. There are exactly half an SCLK period (the edge spacing of R6) from `cs_n` falling to the first edge, and from the last edge to `cs_n` rising. `busy` falls in the same cycle that `cs_n` rises.
- R8: The byte received while byte i is sent is written to buffer address i through `buf_we`/`buf_waddr`/`buf_wdata`. Addresses at or above `run_len` are not written. Runs of MAX_RUN bytes are supported.
- R9: A `start` with `run_len` = 0 or `run_len` > MAX_RUN is ignored, and so is a `start` while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled while idle) |
| run_len | input | LEN_W (8) | Number of bytes in the run |
| cfg | input | 8 | Rate [1:0], CPHA [2], CPOL [3], LSB-first [5] |
| busy | output | 1 | Run in progress, until chip select released |
| buf_raddr | output | LEN_W (8) | Buffer read address |
| buf_rdata | input | 8 | Buffer read data for `buf_raddr`, same cycle |
| buf_we | output | 1 | Buffer write strobe for a received byte |
| buf_waddr | output | LEN_W (8) | Buffer write address |
| buf_wdata | output | 8 | Received byte |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Active-low chip select |

## Verification
The hardest cases to reach from the ports are the byte boundaries inside a multi-byte run, with every phase and bit-order setting. At these boundaries the last sample of one byte, the write-back and the load of the next byte all fall on the same SCLK edge. The bench drives each vector against a behavioural slave that follows the configured mode. The slave sends a known pattern and records what it samples on MOSI. Because the slave's data differs from the transmitted data, a byte misplaced or bit-reversed at a boundary shows up both in the buffer and in the slave's capture. A further run changes the configuration and pulses `start` in the middle of a transfer, so that capture-at-start behaviour is exercised.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

    // Configuration byte layout (bit 7 at the left)
    typedef struct packed {
        logic [1:0] spare_hi;
        logic       lsb_first;
        logic       spare_mid;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } spi_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TRAIL = 2'd2
    } spi_state_t;

    localparam int unsigned MAX_DIV  = 128;
    localparam int unsigned MAX_HALF = MAX_DIV / 2;

    // System clocks per SCLK half period for a rate code: 2, 8, 32, 64
    function automatic int unsigned half_period(input logic [1:0] code);
        return (code == 2'd3) ? MAX_HALF : (int'(2) << (2 * code));
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

endpackage

// File: rtl/spi_bm_rate.sv
module spi_bm_rate
    import spi_bm_pkg::*;
#(
    parameter int CNT_W = $clog2(MAX_HALF)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        half_m1 = CNT_W'(half_period(rate) - 1);
        tick    = run && (cnt_q == half_m1);
        cnt_d   = (!run || tick) ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: a half period is never shorter than two system clocks
    a_r6_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/spi_bm_core.sv
module spi_bm_core
    import spi_bm_pkg::*;
#(
    parameter int MAX_RUN = 200,
    parameter int LEN_W   = $clog2(MAX_RUN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] run_len,
    input  logic [7:0]       cfg_in,
    input  logic             tick,
    input  logic [7:0]       buf_rdata,
    input  logic             miso,
    output logic             run,
    output logic [1:0]       rate,
    output logic             busy,
    output logic [LEN_W-1:0] buf_raddr,
    output logic             buf_we,
    output logic [LEN_W-1:0] buf_waddr,
    output logic [7:0]       buf_wdata,
    output logic             sclk,
    output logic             mosi,
    output logic             cs_n
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_RUN);

    typedef struct packed {
        spi_state_t       state;
        spi_cfg_t         cfg;
        logic [7:0]       sr;
        logic [7:0]       rx;
        logic             mosi;
        logic             sclk;
        logic             cs_n;
        logic [3:0]       edge_n;
        logic [LEN_W-1:0] widx;
        logic [LEN_W-1:0] ridx;
        logic [LEN_W-1:0] len;
        logic             we;
        logic [LEN_W-1:0] waddr;
        logic [7:0]       wdata;
    } core_reg_t;

    core_reg_t q, d;
    spi_cfg_t  cfg_new;
    spi_cfg_t  cfg_use;
    logic [7:0] ld_byte;
    logic [7:0] rx_full;
    logic       sample;

    always_comb begin
        cfg_new = spi_cfg_t'(cfg_in);
        cfg_use = (q.state == ST_IDLE) ? cfg_new : q.cfg;
        ld_byte = cfg_use.lsb_first ? rev8(buf_rdata) : buf_rdata;
        sample  = (~q.edge_n[0]) ^ q.cfg.cpha;
        rx_full = sample ? {q.rx[6:0], miso} : q.rx;

        d    = q;
        d.we = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start && run_len != '0 && run_len <= MAX_LEN) begin
                    d.state  = ST_SHIFT;
                    d.cfg    = cfg_new;
                    d.len    = run_len;
                    d.cs_n   = 1'b0;
                    d.sclk   = cfg_new.cpol;
                    d.edge_n = '0;
                    d.widx   = '0;
                    d.ridx   = LEN_W'(1);
                    d.sr     = cfg_new.cpha ? ld_byte : {ld_byte[6:0], 1'b0};
                    if (!cfg_new.cpha) d.mosi = ld_byte[7];
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    d.sclk   = ~q.sclk;
                    d.edge_n = q.edge_n + 4'd1;
                    if (sample) d.rx = {q.rx[6:0], miso};
                    if (q.edge_n == 4'd15) begin
                        d.we    = 1'b1;
                        d.waddr = q.widx;
                        d.wdata = q.cfg.lsb_first ? rev8(rx_full) : rx_full;
                        d.widx  = q.widx + LEN_W'(1);
                        if (q.widx == q.len - LEN_W'(1)) begin
                            d.state = ST_TRAIL;
                        end else begin
                            d.ridx = q.ridx + LEN_W'(1);
                            d.sr   = q.cfg.cpha ? ld_byte : {ld_byte[6:0], 1'b0};
                            if (!q.cfg.cpha) d.mosi = ld_byte[7];
                        end
                    end else if (!sample) begin
                        d.mosi = q.sr[7];
                        d.sr   = {q.sr[6:0], 1'b0};
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    d.state = ST_IDLE;
                    d.cs_n  = 1'b1;
                    d.ridx  = '0;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.state  <= ST_IDLE;
            q.cs_n   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign run       = (q.state != ST_IDLE);
    assign busy      = run;
    assign rate      = q.cfg.rate;
    assign buf_raddr = q.ridx;
    assign buf_we    = q.we;
    assign buf_waddr = q.waddr;
    assign buf_wdata = q.wdata;
    assign sclk      = q.sclk;
    assign mosi      = q.mosi;
    assign cs_n      = q.cs_n;

    // R7: chip select only asserted inside a run
    a_r7_cs_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);
    // R7: busy drops together with chip select release
    a_r7_release_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cs_n);
    // R4: between runs SCLK rests at the captured polarity
    a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == q.cfg.cpol));
    // R6: SCLK moves inside a run only on a rate tick
    a_r6_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && (sclk != $past(sclk))) |-> $past(tick));
    // R8: write-backs stay inside the run
    a_r8_write_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (busy && buf_waddr < q.len));
    // R3: captured configuration holds for the whole run
    a_r3_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(q.cfg));
    // R9: an out-of-range length never starts a run
    a_r9_bad_len: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (run_len == '0 || run_len > MAX_LEN)) |=> !busy);

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_bm_pkg::*;
#(
    parameter int MAX_RUN = 200,
    localparam int LEN_W  = $clog2(MAX_RUN + 1),
    localparam int CNT_W  = $clog2(MAX_HALF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] run_len,
    input  logic [7:0]       cfg,
    output logic             busy,
    output logic [LEN_W-1:0] buf_raddr,
    input  logic [7:0]       buf_rdata,
    output logic             buf_we,
    output logic [LEN_W-1:0] buf_waddr,
    output logic [7:0]       buf_wdata,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n
);
    logic       run;
    logic       tick;
    logic [1:0] rate;

    spi_bm_rate #(.CNT_W(CNT_W)) u_rate (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .rate (rate),
        .tick (tick)
    );

    spi_bm_core #(.MAX_RUN(MAX_RUN), .LEN_W(LEN_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .run_len  (run_len),
        .cfg_in   (cfg),
        .tick     (tick),
        .buf_rdata(buf_rdata),
        .miso     (miso),
        .run      (run),
        .rate     (rate),
        .busy     (busy),
        .buf_raddr(buf_raddr),
        .buf_we   (buf_we),
        .buf_waddr(buf_waddr),
        .buf_wdata(buf_wdata),
        .sclk     (sclk),
        .mosi     (mosi),
        .cs_n     (cs_n)
    );

endmodule

// File: tb/test_spi_byte_master.sv
`timescale 1ns/1ps
module test_spi_byte_master;
    localparam int MAX_RUN = 200;
    localparam int LEN_W   = 8;
    localparam int LIMIT   = 150000;
    localparam int NVEC    = 8;
    // {cfg, len, seed}; cfg: [1:0] rate, [2] cpha, [3] cpol, [5] lsb-first
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h00, 8'd3, 8'd11}, {8'h05, 8'd2, 8'd23},
        {8'h0A, 8'd2, 8'd37}, {8'h0F, 8'd1, 8'd41},
        {8'h20, 8'd4, 8'd59}, {8'h2D, 8'd3, 8'd67},
        {8'h24, 8'd5, 8'd71}, {8'h28, 8'd2, 8'd83}};

    logic clk = 0, rst_n = 0, start = 0, miso = 0;
    logic [LEN_W-1:0] run_len = '0, buf_raddr, buf_waddr;
    logic [7:0] cfg = '0, buf_wdata, buf_rdata;
    logic busy, buf_we, sclk, mosi, cs_n;

    logic [7:0] mem [256];
    logic [7:0] txb [256];
    logic [7:0] slv [256];
    logic [7:0] cap [256];
    int checks = 0, fails = 0, cyc = 0;

    // slave and monitor state
    bit b_cpol, b_cpha, b_lsb;
    int b_len, dcnt, scnt, edges;
    int t_csf, t_e1, t_e2, t_last, t_csr, t_bf;
    logic p_cs = 1, p_sclk = 0, p_busy = 0;

    always #5 clk = ~clk;

    spi_byte_master #(.MAX_RUN(MAX_RUN)) i_spi_byte_master (
        .clk(clk), .rst_n(rst_n), .start(start), .run_len(run_len), .cfg(cfg),
        .busy(busy), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

    assign buf_rdata = mem[buf_raddr];
    always @(posedge clk) if (buf_we) mem[buf_waddr] <= buf_wdata;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == LIMIT) begin
            fails = fails + 1;
            $display("FAIL watchdog expired act=%0d exp=<%0d", cyc, LIMIT);
            summary();
            $finish;
        end
    end

    function automatic logic sbit(input int n);
        int j = n / 8, k = n % 8;
        if (j >= b_len) return 1'b0;
        return b_lsb ? slv[j][k] : slv[j][7-k];
    endfunction

    // behavioural slave and edge monitor, evaluated away from the active edge
    always @(negedge clk) begin
        if (!cs_n && p_cs) begin
            t_csf = cyc; dcnt = 0; scnt = 0;
            if (!b_cpha) begin miso = sbit(0); dcnt = 1; end
        end else if (!cs_n && !p_cs && sclk != p_sclk) begin
            edges = edges + 1;
            if (edges == 1) t_e1 = cyc;
            if (edges == 2) t_e2 = cyc;
            t_last = cyc;
            if ((sclk != b_cpol) ^ b_cpha) begin
                cap[scnt/8][b_lsb ? (scnt % 8) : (7 - scnt % 8)] = mosi;
                scnt = scnt + 1;
            end else begin
                miso = sbit(dcnt); dcnt = dcnt + 1;
            end
        end
        if (cs_n && !p_cs) t_csr = cyc;
        if (!busy && p_busy) t_bf = cyc;
        p_cs = cs_n; p_sclk = sclk; p_busy = busy;
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    task automatic do_run(input logic [7:0] c, input int len, input logic [7:0] seed,
                          input bit disturb);
        int h = (c[1:0] == 2'd3) ? 64 : (2 << (2 * c[1:0]));
        int err_rx = 0, err_tx = 0;
        for (int i = 0; i < 256; i++) begin
            txb[i] = 8'(seed * 37 + i * 29 + 5);
            slv[i] = ~8'(seed + i * 53) ^ 8'h5A;
            mem[i] = txb[i];
            cap[i] = 8'h00;
        end
        b_cpol = c[3]; b_cpha = c[2]; b_lsb = c[5]; b_len = len;
        edges = 0;
        @(negedge clk);
        cfg = c; run_len = LEN_W'(len); start = 1;
        @(negedge clk);
        start = 0;
        chk(busy == 1 && cs_n == 0, "R2 run accepted busy", int'(busy), 1);
        chk(sclk == c[3], "R4 sclk at CPOL level after start", int'(sclk), int'(c[3]));
        if (disturb) begin
            repeat (20) @(negedge clk);
            cfg = 8'h2F; run_len = 8'd5; start = 1;
            @(negedge clk);
            start = 0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < len; i++) begin
            if (mem[i] !== slv[i]) err_rx++;
            if (cap[i] !== txb[i]) err_tx++;
        end
        chk(err_rx == 0, "R8 R4 R5 received bytes in buffer", err_rx, 0);
        chk(err_tx == 0, "R4 R5 slave saw transmitted bytes", err_tx, 0);
        chk(mem[len] == txb[len], "R8 slot past run untouched", int'(mem[len]), int'(txb[len]));
        chk(edges == 16 * len, "R4 edge count", edges, 16 * len);
        chk(t_e1 - t_csf == h, "R7 cs to first edge", t_e1 - t_csf, h);
        chk(t_e2 - t_e1 == h, "R6 edge spacing", t_e2 - t_e1, h);
        chk(t_csr - t_last == h, "R7 last edge to cs release", t_csr - t_last, h);
        chk(t_bf == t_csr, "R7 busy falls with cs", t_bf, t_csr);
        chk(sclk == c[3], "R4 sclk idles at CPOL", int'(sclk), int'(c[3]));
        if (disturb)
            chk(edges == 16 * len, "R3 R9 run kept its length and cfg", edges, 16 * len);
    endtask

    task automatic bad_start(input int len);
        @(negedge clk);
        run_len = LEN_W'(len); cfg = 8'h00; start = 1;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        chk(busy == 0 && cs_n == 1, "R9 bad length ignored", int'(busy), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        chk(sclk == 0 && cs_n == 1 && busy == 0 && buf_we == 0, "R1 state in reset",
            int'({sclk, cs_n, busy, buf_we}), 4);
        rst_n = 1;
        @(negedge clk);
        chk(sclk == 0 && cs_n == 1 && busy == 0, "R1 state after reset",
            int'({sclk, cs_n, busy}), 2);

        for (int v = 0; v < NVEC; v++)
            do_run(VEC[v][23:16], int'(VEC[v][15:8]), VEC[v][7:0], 1'b0);

        bad_start(0);
        bad_start(MAX_RUN + 1);
        do_run(8'h01, 2, 8'd97, 1'b1);      // R3: mid-run cfg change and start
        do_run(8'h00, MAX_RUN, 8'd5, 1'b0); // R8: longest run

        summary();
        $finish;
    end
endmodule